// File: doc/BRIEF.md
# RTC Host Register Interface with Interrupt Status

This block is the part of a real-time clock that a host processor talks to. The host reaches it through two byte-wide ports. Writing the index port chooses one register. The data port then reads or writes the register that was chosen. The block holds four registers:

- a rate/divider control register with an update-in-progress view;
- a mode and interrupt-enable control register;
- an interrupt flag register that clears on read;
- a validity status register.

The calendar and rate-generator blocks live elsewhere. They send one-cycle event pulses to this block. The block latches those pulses into flags, forms an interrupt summary, and drives the interrupt request line.

Interrupt state is held by a two-state machine:

- `IRQ_QUIET`: no enabled source is pending.
- `IRQ_RAISED`: the summary bit is set and `irq` is high.

It has two transitions:

- `QUIET->RAISED` is taken on the clock after any flag is set while its enable is also set, unless the flag register is being read in that cycle.
- `RAISED->QUIET` is taken when the host reads the flag register, or on any reset.

The data-port decoder sorts each host cycle into one of five kinds: none, index write, data write, data read, index-port read.

Top module: `rtc_host_regs`

## Requirements
- R1: A write to port 0 (`host_port`=0) loads the register index from bits 6:0 of `host_wdata`. Bit 7 is dropped. Later port-1 accesses go to the indexed register. Index 0x0A is control A, 0x0B is control B, 0x0C is flags, 0x0D is status.
- R2: In control A, bits 6:0 can be written and read back. Bits 3:0 drive `cfg_rate` and bits 6:4 drive `cfg_div`. Bit 7 reads as the value of `cal_uip` in the read cycle. Host writes to bit 7 have no effect.
- R3: Control B is eight writable bits that read back unchanged and drive `cfg_ctrl`. Bit 4 enables the update source, bit 5 the alarm source and bit 6 the periodic source.
- R4: The flag register latches `evt_update` into bit 4, `evt_alarm` into bit 5 and `evt_periodic` into bit 6, whatever the enables are. A flag stays set until the flag register is read or a reset occurs.
- R5: Flag-register bit 7 and `irq` rise on the clock after some flag and its enable are both set. A source whose enable is clear never raises them.
- R6: A read of the flag register returns its value, including bit 7, as it was before the read. The same clock edge clears every bit, and `irq` falls.
- R7: An event pulse in the same cycle as a flag-register read is not lost. It is absent from the returned byte and present afterwards.
- R8: Host writes to the flag and status registers have no effect.
- R9: A host reset (`rst_n` low at a clock edge) clears control B bits 6:3, all flags, bit 7 and `irq`, and sets the index to 0. It sets status bit 7, so the status register reads 0x80. Control A and control B bits 7, 2:0 keep their values.
- R10: A power-on reset (`por_n` low) clears every register, the index and status bit 7 to zero.
- R11: A data-port read of any index other than 0x0A..0x0D returns 0x00. A read of port 0 also returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous host reset, active low |
| host_port | input | 1 | 0 = index port, 1 = data port |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, registered, held until the next read |
| evt_update | input | 1 | Update-ended pulse from the calendar |
| evt_alarm | input | 1 | Alarm-match pulse from the calendar |
| evt_periodic | input | 1 | Periodic tick from the rate generator |
| cal_uip | input | 1 | Calendar update-in-progress status |
| irq | output | 1 | Interrupt request, active high |
| cfg_rate | output | 4 | Rate selection field of control A |
| cfg_div | output | 3 | Divider field of control A |
| cfg_ctrl | output | 8 | Control B contents |

## Verification
The checker assumes the host never raises `host_rd` and `host_wr` in the same cycle. It also assumes the host changes the index only through explicit port-0 writes. The bench drives each access as a single-cycle strobe set up at the falling edge, and it never overlaps a read with a write. Event pulses last one cycle and may coincide with a flag-register read. The bench deliberately creates that overlap for the lost-event case and otherwise keeps events apart from host accesses.

// File: rtl/rtc_host_pkg.sv
package rtc_host_pkg;
    localparam int IDX_W    = 7;
    localparam int DATA_W   = 8;
    localparam int N_SRC    = 3;
    localparam int C_FLAG_LO = 4;
    localparam int C_SUM    = 7;
    localparam int B_EN_LO  = 4;
    localparam int B_KEEP_W = 4;

    localparam logic [IDX_W-1:0] IDX_CTL_A  = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_CTL_B  = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_FLAGS  = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_STATUS = 7'h0D;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_INDEX,
        ACC_WRITE,
        ACC_READ,
        ACC_PORT0_READ
    } acc_kind_t;
endpackage

// File: rtl/rtc_host_decode.sv
module rtc_host_decode
    import rtc_host_pkg::*;
#(
    parameter int W = IDX_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         rst_n,
    input  logic         host_port,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [W-1:0] idx_wdata,
    output acc_kind_t    acc,
    output logic [W-1:0] idx_q,
    output logic         sel_a,
    output logic         sel_b,
    output logic         sel_c,
    output logic         sel_d
);
    always_comb begin
        unique case ({host_wr, host_rd})
            2'b10:   acc = host_port ? ACC_WRITE : ACC_INDEX;
            2'b01:   acc = host_port ? ACC_READ : ACC_PORT0_READ;
            default: acc = ACC_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            idx_q <= '0;
        end else if (!rst_n) begin
            idx_q <= '0;
        end else if (acc == ACC_INDEX) begin
            idx_q <= idx_wdata;
        end
    end

    always_comb begin
        sel_a = (idx_q == W'(IDX_CTL_A));
        sel_b = (idx_q == W'(IDX_CTL_B));
        sel_c = (idx_q == W'(IDX_FLAGS));
        sel_d = (idx_q == W'(IDX_STATUS));
    end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                flags_q[i] <= 1'b0;
            end else if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (clr) begin
                flags_q[i] <= evt[i];
            end else begin
                flags_q[i] <= flags_q[i] | evt[i];
            end
        end
    end
endmodule

// File: rtl/rtc_irq_fsm.sv
module rtc_irq_fsm
    import rtc_host_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic pending,
    input  logic clr,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= IRQ_QUIET;
        end else if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending && !clr) state_d = IRQ_RAISED;
            IRQ_RAISED: if (clr) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
    import rtc_host_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        host_port,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        evt_update,
    input  logic        evt_alarm,
    input  logic        evt_periodic,
    input  logic        cal_uip,
    output logic        irq,
    output logic [3:0]  cfg_rate,
    output logic [2:0]  cfg_div,
    output logic [7:0]  cfg_ctrl
);
    localparam int A_W = DATA_W - 1;

    acc_kind_t         acc;
    logic [IW-1:0]     idx_q;
    logic              sel_a, sel_b, sel_c, sel_d;
    logic [A_W-1:0]    a_q;
    logic [DATA_W-1:0] b_q;
    logic              vrt_q;
    logic [N_SRC-1:0]  flags_q;
    logic [N_SRC-1:0]  evt_vec;
    logic              clr_c;
    logic              pending;
    logic [DATA_W-1:0] rd_mux;

    rtc_host_decode #(.W(IW)) u_decode (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .host_port (host_port),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .idx_wdata (host_wdata[IW-1:0]),
        .acc       (acc),
        .idx_q     (idx_q),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_c     (sel_c),
        .sel_d     (sel_d)
    );

    assign evt_vec = {evt_periodic, evt_alarm, evt_update};
    assign clr_c   = (acc == ACC_READ) && sel_c;
    assign pending = |(flags_q & b_q[B_EN_LO +: N_SRC]);

    rtc_flag_bank #(.N(N_SRC)) u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .evt     (evt_vec),
        .clr     (clr_c),
        .flags_q (flags_q)
    );

    rtc_irq_fsm u_irq (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .pending (pending),
        .clr     (clr_c),
        .irq     (irq)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            a_q <= '0;
        end else if (acc == ACC_WRITE && sel_a) begin
            a_q <= host_wdata[A_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            b_q <= '0;
        end else if (!rst_n) begin
            b_q[B_EN_LO-1 +: B_KEEP_W] <= '0;
        end else if (acc == ACC_WRITE && sel_b) begin
            b_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            vrt_q <= 1'b0;
        end else if (!rst_n) begin
            vrt_q <= 1'b1;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_a) begin
            rd_mux = {cal_uip, a_q};
        end else if (sel_b) begin
            rd_mux = b_q;
        end else if (sel_c) begin
            rd_mux[C_SUM] = irq;
            rd_mux[C_FLAG_LO +: N_SRC] = flags_q;
        end else if (sel_d) begin
            rd_mux[DATA_W-1] = vrt_q;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            host_rdata <= '0;
        end else if (acc == ACC_READ) begin
            host_rdata <= rd_mux;
        end else if (acc == ACC_PORT0_READ) begin
            host_rdata <= '0;
        end
    end

    assign cfg_rate = a_q[3:0];
    assign cfg_div  = a_q[6:4];
    assign cfg_ctrl = b_q;
endmodule

// File: rtl/rtc_host_regs_chk.sv
module rtc_host_regs_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       host_port,
    input logic       host_wr,
    input logic       host_rd,
    input logic [6:0] idx,
    input logic [2:0] flags,
    input logic [2:0] ens,
    input logic [2:0] evts,
    input logic       irq,
    input logic       cal_uip,
    input logic       rdata_msb
);
    logic c_read;
    logic a_read;
    assign c_read = host_rd && !host_wr && host_port && (idx == 7'h0C);
    assign a_read = host_rd && !host_wr && host_port && (idx == 7'h0A);

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !(host_rd && host_wr)); // R1
    AST_UIP_VISIBLE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        a_read |=> (rdata_msb == $past(cal_uip))); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !c_read |=> ((flags & $past(flags)) == $past(flags))); // R4
    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        irq |-> (flags != 3'b000)); // R5
    AST_IRQ_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (((flags & ens) != 3'b000) && !c_read) |=> irq); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (c_read && evts == 3'b000) |=> (flags == 3'b000 && !irq)); // R6
    AST_EVT_SURVIVES: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        c_read |=> (flags == $past(evts))); // R7
endmodule

bind rtc_host_regs rtc_host_regs_chk chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .host_port (host_port),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .idx       (idx_q),
    .flags     (flags_q),
    .ens       (b_q[6:4]),
    .evts      (evt_vec),
    .irq       (irq),
    .cal_uip   (cal_uip),
    .rdata_msb (host_rdata[7])
);

// File: tb/rtc_host_regs_tb_top.sv
`timescale 1ns/1ps
module rtc_host_regs_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_port = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       evt_update = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_periodic = 1'b0;
    logic       cal_uip = 1'b0;
    logic       irq;
    logic [3:0] cfg_rate;
    logic [2:0] cfg_div;
    logic [7:0] cfg_ctrl;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    rtc_host_regs dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .host_port(host_port), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_update(evt_update), .evt_alarm(evt_alarm), .evt_periodic(evt_periodic),
        .cal_uip(cal_uip), .irq(irq),
        .cfg_rate(cfg_rate), .cfg_div(cfg_div), .cfg_ctrl(cfg_ctrl)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per read strobe seen at a rising edge
    initial begin
        forever begin
            @(posedge clk);
            if (host_rd) begin
                #2;
                if (sb_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL scoreboard: read with no expected item actual=%02h expected=none", host_rdata);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(host_rdata, it.exp, it.tag);
                end
            end
        end
    end

    task automatic wr_port(input logic p, input logic [7:0] v);
        @(negedge clk);
        host_port = p; host_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic p, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sb_q.push_back('{exp, tag});
        host_port = p; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        wr_port(1'b0, idx);
        rd_expect(1'b1, exp, tag);
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
        wr_port(1'b0, idx);
        wr_port(1'b1, v);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) evt_update = 1'b1;
        if (which == 1) evt_alarm = 1'b1;
        if (which == 2) evt_periodic = 1'b1;
        @(negedge clk);
        evt_update = 1'b0; evt_alarm = 1'b0; evt_periodic = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle(3);
        por_n = 1'b1;
        idle(1);
        rst_n = 1'b1;
        idle(1);
        // reset state
        check({7'd0, irq}, 8'h00, "R10 irq low after reset");
        check(cfg_ctrl, 8'h00, "R10 control B zero after power-on");
        rd_expect(1'b1, 8'h00, "R11 index 0 after reset reads zero");
        reg_read(8'h0D, 8'h80, "R9 status valid after host reset");
        reg_read(8'h0C, 8'h00, "R10 flags clear after reset");

        // control A, index bit 7 dropped
        reg_write(8'h8A, 8'hFF);
        rd_expect(1'b1, 8'h7F, "R1 R2 control A via index 0x8A, uip low");
        check({4'd0, cfg_rate}, 8'h0F, "R2 cfg_rate");
        check({5'd0, cfg_div}, 8'h07, "R2 cfg_div");
        cal_uip = 1'b1;
        rd_expect(1'b1, 8'hFF, "R2 uip visible in bit 7");
        cal_uip = 1'b0;
        rd_expect(1'b0, 8'h00, "R11 port 0 read returns zero");
        reg_read(8'h20, 8'h00, "R11 unmapped index reads zero");

        // control B, enables off
        reg_write(8'h0B, 8'h87);
        rd_expect(1'b1, 8'h87, "R3 control B readback");
        check(cfg_ctrl, 8'h87, "R3 cfg_ctrl");

        pulse(0);
        pulse(1);
        idle(2);
        check({7'd0, irq}, 8'h00, "R5 disabled sources keep irq low");
        reg_read(8'h0C, 8'h30, "R4 flags latch without enables");
        rd_expect(1'b1, 8'h00, "R6 flags cleared by read");

        // update enable only
        reg_write(8'h0B, 8'h97);
        pulse(2);
        idle(2);
        check({7'd0, irq}, 8'h00, "R5 periodic disabled no irq");
        pulse(0);
        idle(1);
        check({7'd0, irq}, 8'h01, "R5 irq after enabled flag");
        reg_read(8'h0C, 8'hD0, "R6 summary and flags returned");
        check({7'd0, irq}, 8'h00, "R6 irq drops on read");
        rd_expect(1'b1, 8'h00, "R6 second read empty");

        // event coincident with read
        pulse(1);
        @(negedge clk);
        sb_q.push_back('{8'h20, "R7 read shows pre-event value"});
        host_port = 1'b1; host_rd = 1'b1; evt_update = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; evt_update = 1'b0;
        idle(1);
        check({7'd0, irq}, 8'h01, "R7 coincident event raises irq");
        rd_expect(1'b1, 8'h90, "R7 coincident event kept");

        // read-only registers
        reg_write(8'h0C, 8'hFF);
        idle(2);
        rd_expect(1'b1, 8'h00, "R8 flag write ignored");
        check({7'd0, irq}, 8'h00, "R8 irq unaffected by flag write");
        reg_write(8'h0D, 8'h00);
        rd_expect(1'b1, 8'h80, "R8 status write ignored");

        // host reset
        reg_write(8'h0B, 8'hFF);
        pulse(2);
        idle(1);
        check({7'd0, irq}, 8'h01, "R5 periodic enabled raises irq");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check({7'd0, irq}, 8'h00, "R9 irq cleared by host reset");
        check(cfg_ctrl, 8'h87, "R9 control B partial clear");
        rd_expect(1'b1, 8'h00, "R9 index back to 0");
        reg_read(8'h0A, 8'h7F, "R9 control A kept");
        reg_read(8'h0C, 8'h00, "R9 flags cleared");
        reg_read(8'h0D, 8'h80, "R9 status valid");

        // power-on reset alone
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        reg_read(8'h0D, 8'h00, "R10 status zero after power-on only");
        reg_read(8'h0B, 8'h00, "R10 control B zero");
        reg_read(8'h0A, 8'h00, "R10 control A zero");

        idle(2);
        finish_run();
    end
endmodule